// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

The block is a small fully associative cache of page-to-frame translations placed in front of page-table memory. A lookup presents a virtual address and the current address-space identifier. Every stored entry is compared in parallel, and one clock later the block reports hit or miss, the protection bits, the page-valid bit and the physical address. The physical address is the cached frame number placed above the untranslated page offset. When a lookup misses, an external table walker returns the translation through the fill port. Replacement is round-robin. A fill whose page and identifier are already cached overwrites that entry and creates no duplicate.

Each entry keeps the identifier of its owning address space. Translations from several processes can therefore coexist, and a context switch needs no flush. A configuration input turns identifier matching off. In that mode the identifier is ignored on lookups and a context-switch pulse empties the whole buffer. Two software-driven flushes are provided: one removes every entry, the other removes only the entries owned by a given identifier.

Top module: `tlb_asid`

## Requirements
- R1: After reset all response outputs are 0 and no entry is cached, so any lookup misses.
- R2: A lookup presented in cycle k gives its result in cycle k+1 with resp_valid_o=1. On a hit with page-valid set, resp_paddr_o is {frame, lookup_vaddr_i[OFFSET_W-1:0]}. On a miss, resp_hit_o, resp_paddr_o, resp_prot_o and resp_page_valid_o are 0. In a cycle after no lookup, every response output is 0.
- R3: With asid_en_i=1 a hit needs both the page number (lookup_vaddr_i[VA_W-1:OFFSET_W]) and lookup_asid_i to match the entry. The same page can be cached under different identifiers with different frames.
- R4: With asid_en_i=0 the identifier is ignored on lookups, and a match in the lowest-numbered slot wins. A ctx_switch_i pulse flushes every entry while asid_en_i=0 and has no effect while asid_en_i=1.
- R5: A hit on an entry whose page-valid bit is 0 gives resp_hit_o=1, resp_fault_o=1, resp_page_valid_o=0, resp_paddr_o=0, and resp_prot_o equal to the stored protection bits.
- R6: A fill presented in cycle k is seen by lookups presented in cycle k+2 or later. Lookups in cycle k and k+1 see the old contents.
- R7: Fills of new tags take slots in round-robin order. Once the buffer is full, the next new tag evicts the oldest allocation.
- R8: A fill whose page and identifier already exist rewrites that entry in place. It does not advance the replacement pointer.
- R9: flush_all_i removes every entry. flush_asid_i removes only the entries whose identifier equals flush_asid_id_i. Lookups in the cycle after the flush see the result.
- R10: If a flush acts in the same cycle as a pending fill write, the fill is dropped when the flush covers it: a full flush, or an identifier flush whose identifier equals the fill's. Otherwise the fill is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_en_i | input | 1 | Identifier matching enable |
| ctx_switch_i | input | 1 | Context-switch pulse |
| flush_all_i | input | 1 | Remove all entries |
| flush_asid_i | input | 1 | Remove entries of one identifier |
| flush_asid_id_i | input | ASID_W | Identifier to remove |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | VA_W | Virtual address |
| lookup_asid_i | input | ASID_W | Current identifier |
| fill_valid_i | input | 1 | Fill request from the walker |
| fill_vpn_i | input | VA_W-OFFSET_W | Fill page number |
| fill_asid_i | input | ASID_W | Fill identifier |
| fill_pfn_i | input | PFN_W | Fill frame number |
| fill_prot_i | input | PROT_W | Fill protection bits |
| fill_page_valid_i | input | 1 | Fill page-valid bit |
| resp_valid_o | output | 1 | Lookup result present |
| resp_hit_o | output | 1 | Matching entry found |
| resp_fault_o | output | 1 | Hit on an invalid page |
| resp_page_valid_o | output | 1 | Page-valid bit of the hit entry |
| resp_prot_o | output | PROT_W | Protection bits of the hit entry |
| resp_paddr_o | output | PFN_W+OFFSET_W | Physical address |

## Verification
The bench caches the same pages under two identifiers and sweeps both with varying offsets. A design that ignored the identifier would return the wrong frame for one of them. It then drops identifier matching and pulses a context switch in each mode: a design that flushed on every switch, or never flushed, shows up as a miss or a stale hit. It wraps the replacement pointer and then rewrites an existing tag. A pointer that advanced on the rewrite would evict the wrong victim, and a surviving duplicate would show up as an unexpected hit. It places flushes on the same edge as a pending fill write, and probes lookups in the two cycles just after a fill. A design with the wrong priority or the wrong visibility timing returns a hit or a miss where the other is expected.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DEF_ENTRIES = 64;
  localparam int DEF_VA_W    = 32;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_PFN_W   = 20;
  localparam int DEF_ASID_W  = 8;
  localparam int DEF_PROT_W  = 3;

  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_ALL  = 2'd1,
    FL_ASID = 2'd2
  } flush_cmd_e;
endpackage

// File: rtl/tlb_flush_ctrl.sv
module tlb_flush_ctrl import tlb_pkg::*; #(
  parameter int ASID_W = DEF_ASID_W
) (
  input  logic              asid_en_i,
  input  logic              ctx_switch_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i,
  output flush_cmd_e        cmd_o,
  output logic [ASID_W-1:0] id_o
);
  // untagged mode: every context switch drops all translations
  logic all_req;
  assign all_req = flush_all_i | (ctx_switch_i & ~asid_en_i);

  always_comb begin
    if (all_req)           cmd_o = FL_ALL;
    else if (flush_asid_i) cmd_o = FL_ASID;
    else                   cmd_o = FL_NONE;
  end
  assign id_o = flush_asid_id_i;
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array import tlb_pkg::*; #(
  parameter int N      = DEF_ENTRIES,
  parameter int VPN_W  = DEF_VA_W - DEF_OFF_W,
  parameter int PFN_W  = DEF_PFN_W,
  parameter int ASID_W = DEF_ASID_W,
  parameter int PROT_W = DEF_PROT_W,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asid_en_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic [N-1:0]      lk_match_o,
  input  logic [VPN_W-1:0]  st_vpn_i,
  input  logic [ASID_W-1:0] st_asid_i,
  output logic [N-1:0]      st_match_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PFN_W-1:0]  rd_pfn_o,
  output logic [PROT_W-1:0] rd_prot_o,
  output logic              rd_pv_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [PROT_W-1:0] wr_prot_i,
  input  logic              wr_pv_i,
  input  flush_cmd_e        flush_cmd_i,
  input  logic [ASID_W-1:0] flush_id_i
);
  logic [N-1:0]      used_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PROT_W-1:0] prot_q [N];
  logic [N-1:0]      pv_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic wr_hit;
    logic fl_hit;
    assign wr_hit = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign fl_hit = (flush_cmd_i == FL_ALL) ||
                    ((flush_cmd_i == FL_ASID) && (asid_q[i] == flush_id_i));

    // lookup port: identifier ignored in untagged mode
    assign lk_match_o[i] = used_q[i] && (vpn_q[i] == lk_vpn_i) &&
                           (!asid_en_i || (asid_q[i] == lk_asid_i));
    // fill port: always full tag, keeps (page, id) unique
    assign st_match_o[i] = used_q[i] && (vpn_q[i] == st_vpn_i) &&
                           (asid_q[i] == st_asid_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        used_q[i] <= 1'b0;
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
        prot_q[i] <= '0;
        pv_q[i]   <= 1'b0;
      end else if (wr_hit) begin
        used_q[i] <= 1'b1;
        vpn_q[i]  <= wr_vpn_i;
        asid_q[i] <= wr_asid_i;
        pfn_q[i]  <= wr_pfn_i;
        prot_q[i] <= wr_prot_i;
        pv_q[i]   <= wr_pv_i;
      end else if (fl_hit) begin
        used_q[i] <= 1'b0;
      end
    end
  end

  assign rd_pfn_o  = pfn_q[rd_idx_i];
  assign rd_prot_o = prot_q[rd_idx_i];
  assign rd_pv_o   = pv_q[rd_idx_i];
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid import tlb_pkg::*; #(
  parameter int NUM_ENTRIES = DEF_ENTRIES,
  parameter int VA_W        = DEF_VA_W,
  parameter int OFFSET_W    = DEF_OFF_W,
  parameter int PFN_W       = DEF_PFN_W,
  parameter int ASID_W      = DEF_ASID_W,
  parameter int PROT_W      = DEF_PROT_W,
  localparam int VPN_W      = VA_W - OFFSET_W,
  localparam int PA_W       = PFN_W + OFFSET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asid_en_i,
  input  logic              ctx_switch_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_vaddr_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PROT_W-1:0] fill_prot_i,
  input  logic              fill_page_valid_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_fault_o,
  output logic              resp_page_valid_o,
  output logic [PROT_W-1:0] resp_prot_o,
  output logic [PA_W-1:0]   resp_paddr_o
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [VPN_W-1:0]    lk_vpn;
  logic [OFFSET_W-1:0] lk_off;
  assign lk_vpn = lookup_vaddr_i[VA_W-1:OFFSET_W];
  assign lk_off = lookup_vaddr_i[OFFSET_W-1:0];

  flush_cmd_e        fl_cmd;
  logic [ASID_W-1:0] fl_id;

  tlb_flush_ctrl #(.ASID_W(ASID_W)) u_flush (
    .asid_en_i       (asid_en_i),
    .ctx_switch_i    (ctx_switch_i),
    .flush_all_i     (flush_all_i),
    .flush_asid_i    (flush_asid_i),
    .flush_asid_id_i (flush_asid_id_i),
    .cmd_o           (fl_cmd),
    .id_o            (fl_id)
  );

  // fill staging: write lands one edge after capture, lookups never stall
  logic              stg_v;
  logic [VPN_W-1:0]  stg_vpn;
  logic [ASID_W-1:0] stg_asid;
  logic [PFN_W-1:0]  stg_pfn;
  logic [PROT_W-1:0] stg_prot;
  logic              stg_pv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v    <= 1'b0;
      stg_vpn  <= '0;
      stg_asid <= '0;
      stg_pfn  <= '0;
      stg_prot <= '0;
      stg_pv   <= 1'b0;
    end else begin
      stg_v <= fill_valid_i;
      if (fill_valid_i) begin
        stg_vpn  <= fill_vpn_i;
        stg_asid <= fill_asid_i;
        stg_pfn  <= fill_pfn_i;
        stg_prot <= fill_prot_i;
        stg_pv   <= fill_page_valid_i;
      end
    end
  end

  logic stg_kill;
  assign stg_kill = (fl_cmd == FL_ALL) ||
                    ((fl_cmd == FL_ASID) && (stg_asid == fl_id));

  logic [NUM_ENTRIES-1:0] lk_match;
  logic [NUM_ENTRIES-1:0] st_match;
  logic [IDX_W-1:0]       lk_idx;
  logic [IDX_W-1:0]       st_idx;
  logic                   lk_any;
  logic                   st_any;
  logic [IDX_W-1:0]       rr_ptr;
  logic                   wr_en;
  logic [IDX_W-1:0]       wr_idx;
  logic [PFN_W-1:0]       rd_pfn;
  logic [PROT_W-1:0]      rd_prot;
  logic                   rd_pv;

  assign wr_en  = stg_v && !stg_kill;
  assign wr_idx = st_any ? st_idx : rr_ptr;

  tlb_entry_array #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .PROT_W(PROT_W)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .asid_en_i   (asid_en_i),
    .lk_vpn_i    (lk_vpn),
    .lk_asid_i   (lookup_asid_i),
    .lk_match_o  (lk_match),
    .st_vpn_i    (stg_vpn),
    .st_asid_i   (stg_asid),
    .st_match_o  (st_match),
    .rd_idx_i    (lk_idx),
    .rd_pfn_o    (rd_pfn),
    .rd_prot_o   (rd_prot),
    .rd_pv_o     (rd_pv),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_vpn_i    (stg_vpn),
    .wr_asid_i   (stg_asid),
    .wr_pfn_i    (stg_pfn),
    .wr_prot_i   (stg_prot),
    .wr_pv_i     (stg_pv),
    .flush_cmd_i (fl_cmd),
    .flush_id_i  (fl_id)
  );

  tlb_prio_enc #(.N(NUM_ENTRIES)) u_lk_enc (
    .vec_i (lk_match),
    .idx_o (lk_idx),
    .any_o (lk_any)
  );

  tlb_prio_enc #(.N(NUM_ENTRIES)) u_st_enc (
    .vec_i (st_match),
    .idx_o (st_idx),
    .any_o (st_any)
  );

  tlb_rr_ptr #(.N(NUM_ENTRIES)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wr_en && !st_any),
    .ptr_o  (rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o      <= 1'b0;
      resp_hit_o        <= 1'b0;
      resp_fault_o      <= 1'b0;
      resp_page_valid_o <= 1'b0;
      resp_prot_o       <= '0;
      resp_paddr_o      <= '0;
    end else if (lookup_valid_i) begin
      resp_valid_o      <= 1'b1;
      resp_hit_o        <= lk_any;
      resp_fault_o      <= lk_any && !rd_pv;
      resp_page_valid_o <= lk_any && rd_pv;
      resp_prot_o       <= lk_any ? rd_prot : '0;
      resp_paddr_o      <= (lk_any && rd_pv) ? {rd_pfn, lk_off} : '0;
    end else begin
      resp_valid_o      <= 1'b0;
      resp_hit_o        <= 1'b0;
      resp_fault_o      <= 1'b0;
      resp_page_valid_o <= 1'b0;
      resp_prot_o       <= '0;
      resp_paddr_o      <= '0;
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int N    = 64,
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            asid_en_i,
  input logic            flush_all_i,
  input logic            lookup_valid_i,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            resp_fault_o,
  input logic [PA_W-1:0] resp_paddr_o,
  input logic [N-1:0]    lk_match
);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!resp_valid_o && !resp_hit_o));

  // R5
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_hit_o);

  // R2
  no_addr_leak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!resp_hit_o || resp_fault_o) |-> (resp_paddr_o == '0));

  // R3
  unique_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asid_en_i |-> $onehot0(lk_match));

  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && $past(flush_all_i)) |=> !resp_hit_o);
endmodule

bind tlb_asid tlb_asid_chk #(.N(NUM_ENTRIES), .PA_W(PA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .asid_en_i      (asid_en_i),
  .flush_all_i    (flush_all_i),
  .lookup_valid_i (lookup_valid_i),
  .resp_valid_o   (resp_valid_o),
  .resp_hit_o     (resp_hit_o),
  .resp_fault_o   (resp_fault_o),
  .resp_paddr_o   (resp_paddr_o),
  .lk_match       (lk_match)
);

// File: tb/tlb_asid_tb.sv
module tlb_asid_tb;
  localparam int N      = 8;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;
  localparam int PROT_W = 3;
  localparam int PA_W   = PFN_W + OFF_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic              asid_en = 1'b1, ctx_sw = 1'b0, fl_all = 1'b0, fl_asid = 1'b0;
  logic [ASID_W-1:0] fl_id = '0;
  logic              lk_v = 1'b0;
  logic [VA_W-1:0]   lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              f_v = 1'b0;
  logic [VPN_W-1:0]  f_vpn = '0;
  logic [ASID_W-1:0] f_asid = '0;
  logic [PFN_W-1:0]  f_pfn = '0;
  logic [PROT_W-1:0] f_prot = '0;
  logic              f_pv = 1'b0;
  logic              r_v, r_hit, r_fault, r_pv;
  logic [PROT_W-1:0] r_prot;
  logic [PA_W-1:0]   r_pa;

  tlb_asid #(.NUM_ENTRIES(N), .VA_W(VA_W), .OFFSET_W(OFF_W), .PFN_W(PFN_W),
             .ASID_W(ASID_W), .PROT_W(PROT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .asid_en_i(asid_en), .ctx_switch_i(ctx_sw),
    .flush_all_i(fl_all), .flush_asid_i(fl_asid), .flush_asid_id_i(fl_id),
    .lookup_valid_i(lk_v), .lookup_vaddr_i(lk_va), .lookup_asid_i(lk_asid),
    .fill_valid_i(f_v), .fill_vpn_i(f_vpn), .fill_asid_i(f_asid),
    .fill_pfn_i(f_pfn), .fill_prot_i(f_prot), .fill_page_valid_i(f_pv),
    .resp_valid_o(r_v), .resp_hit_o(r_hit), .resp_fault_o(r_fault),
    .resp_page_valid_o(r_pv), .resp_prot_o(r_prot), .resp_paddr_o(r_pa)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [PFN_W-1:0] frame_of(int vpn, int asid);
    return PFN_W'(vpn * 3 + asid * 257 + 7);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fill(int vpn, int asid, logic [PFN_W-1:0] pfn, int prot, logic pv);
    f_v = 1'b1; f_vpn = VPN_W'(vpn); f_asid = ASID_W'(asid);
    f_pfn = pfn; f_prot = PROT_W'(prot); f_pv = pv;
    step();
    f_v = 1'b0;
    step();
  endtask

  // lookup then compare the registered result one edge later
  task automatic look(string tag, int vpn, int off, int asid, logic hit,
                      logic [PFN_W-1:0] pfn, int prot, logic pv);
    lk_v = 1'b1; lk_va = {VPN_W'(vpn), OFF_W'(off)}; lk_asid = ASID_W'(asid);
    step();
    lk_v = 1'b0;
    chk({tag, " valid"}, 32'(r_v), 32'd1);
    chk({tag, " hit"}, 32'(r_hit), 32'(hit));
    if (hit) begin
      chk({tag, " fault"}, 32'(r_fault), 32'(!pv));
      chk({tag, " prot"}, 32'(r_prot), 32'(prot));
      chk({tag, " paddr"}, r_pa, pv ? {pfn, OFF_W'(off)} : 32'd0);
    end else begin
      chk({tag, " paddr"}, r_pa, 32'd0);
    end
  endtask

  task automatic pulse_all();
    fl_all = 1'b1; step(); fl_all = 1'b0;
  endtask

  task automatic pulse_asid(int id);
    fl_asid = 1'b1; fl_id = ASID_W'(id); step(); fl_asid = 1'b0;
  endtask

  task automatic pulse_ctx();
    ctx_sw = 1'b1; step(); ctx_sw = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step();
    // R1 reset state
    chk("R1 resp_valid", 32'(r_v), 0);
    chk("R1 hit", 32'(r_hit), 0);
    chk("R1 paddr", r_pa, 0);
    rst_ni = 1'b1;
    step();
    look("R1 empty", 0, 0, 0, 1'b0, '0, 0, 1'b0);

    // R2 R3: same pages under two identifiers, full buffer
    for (int a = 1; a <= 2; a++)
      for (int v = 0; v < 4; v++) fill(v, a, frame_of(v, a), v % 8, 1'b1);
    for (int a = 1; a <= 2; a++)
      for (int v = 0; v < 4; v++)
        look("R3 tagged hit", v, v * 1111 + a, a, 1'b1, frame_of(v, a), v % 8, 1'b1);
    for (int v = 0; v < 4; v++) look("R3 foreign id miss", v, 5, 3, 1'b0, '0, 0, 1'b0);
    // R2 idle cycle gives quiet outputs
    step();
    chk("R2 idle valid", 32'(r_v), 0);

    // R4 untagged mode: lowest slot (id 1 entry) wins
    asid_en = 1'b0;
    look("R4 id ignored", 2, 9, 7, 1'b1, frame_of(2, 1), 2, 1'b1);
    asid_en = 1'b1;
    pulse_ctx();
    look("R4 tagged switch keeps", 3, 1, 2, 1'b1, frame_of(3, 2), 3, 1'b1);
    asid_en = 1'b0;
    pulse_ctx();
    asid_en = 1'b1;
    for (int a = 1; a <= 2; a++)
      for (int v = 0; v < 4; v++) look("R4 untagged switch flush", v, 0, a, 1'b0, '0, 0, 1'b0);

    // R5 invalid page faults
    fill(16, 1, frame_of(16, 1), 5, 1'b0);
    look("R5 fault", 16, 77, 1, 1'b1, '0, 5, 1'b0);
    chk("R5 page_valid", 32'(r_pv), 0);

    // R6 visibility two cycles after the fill
    f_v = 1'b1; f_vpn = VPN_W'(32); f_asid = 1; f_pfn = frame_of(32, 1); f_prot = 1; f_pv = 1'b1;
    lk_v = 1'b1; lk_va = {VPN_W'(32), OFF_W'(4)}; lk_asid = 1;
    step();
    f_v = 1'b0;
    chk("R6 same-cycle miss", 32'(r_hit), 0);
    step();
    chk("R6 next-cycle miss", 32'(r_hit), 0);
    step();
    lk_v = 1'b0;
    chk("R6 later hit", 32'(r_hit), 1);
    chk("R6 paddr", r_pa, {frame_of(32, 1), OFF_W'(4)});

    // R7 R8 round-robin with in-place rewrite
    pulse_all();
    for (int v = 48; v < 48 + N; v++) fill(v, 1, frame_of(v, 1), 2, 1'b1);
    fill(48, 1, frame_of(48, 9), 4, 1'b1);
    look("R8 rewritten in place", 48, 3, 1, 1'b1, frame_of(48, 9), 4, 1'b1);
    fill(64, 1, frame_of(64, 1), 6, 1'b1);
    look("R7 oldest evicted", 48, 3, 1, 1'b0, '0, 0, 1'b0);
    for (int v = 49; v < 48 + N; v++)
      look("R7 R8 others kept", v, v, 1, 1'b1, frame_of(v, 1), 2, 1'b1);
    look("R7 new entry", 64, 8, 1, 1'b1, frame_of(64, 1), 6, 1'b1);
    fill(80, 2, frame_of(80, 2), 0, 1'b1);
    look("R7 second victim", 49, 0, 1, 1'b0, '0, 0, 1'b0);

    // R9 identifier flush then full flush
    pulse_asid(1);
    look("R9 other id kept", 80, 2, 2, 1'b1, frame_of(80, 2), 0, 1'b1);
    look("R9 id flushed", 50, 2, 1, 1'b0, '0, 0, 1'b0);
    look("R9 id flushed new", 64, 2, 1, 1'b0, '0, 0, 1'b0);
    pulse_all();
    look("R9 full flush", 80, 2, 2, 1'b0, '0, 0, 1'b0);

    // R10 flush on the edge of the pending write
    f_v = 1'b1; f_vpn = VPN_W'(96); f_asid = 2; f_pfn = frame_of(96, 2); f_prot = 3; f_pv = 1'b1;
    step(); f_v = 1'b0; pulse_asid(2);
    look("R10 matching id drops fill", 96, 1, 2, 1'b0, '0, 0, 1'b0);
    f_v = 1'b1; f_vpn = VPN_W'(97); f_asid = 2; f_pfn = frame_of(97, 2);
    step(); f_v = 1'b0; pulse_asid(1);
    look("R10 other id keeps fill", 97, 1, 2, 1'b1, frame_of(97, 2), 3, 1'b1);
    f_v = 1'b1; f_vpn = VPN_W'(98); f_asid = 2; f_pfn = frame_of(98, 2);
    step(); f_v = 1'b0; pulse_all();
    look("R10 full flush drops fill", 98, 1, 2, 1'b0, '0, 0, 1'b0);

    summary();
  end
endmodule